// File: doc/BRIEF.md
# Save-State Header Pointer Register

This block keeps the address at which a processor writes its save-state header when it enters system management mode. It holds a dword-aligned pointer and a valid flag. When the mode is entered and the flag is clear, the block works out the pointer from the managed memory region: the region base plus the region size, which is the top of the region. It then marks the pointer valid and hands that address to the save logic. When the flag is already set, the stored pointer is used unchanged.

Any write to the region descriptor invalidates the pointer. The next entry then recomputes it from the new region. Software can read the register and can write it, including the valid flag. This lets a handler place the header somewhere other than the region top, for example before it allows a nested entry. The save address is returned with a one-cycle ready pulse after the entry request, so the header address is settled before any state is stored.

Top module: `smm_hdr_ptr`

## Requirements
- R1: After hardware reset, the register reads as all zeros (pointer zero, valid flag clear) and `save_valid` is low.
- R2: A software write loads bits AW-1..2 of `sw_wdata` as the pointer and bit 0 as the valid flag. From the next cycle, `sw_rdata` returns the pointer in bits AW-1..2, zero in bit 1 and the flag in bit 0. Bit 1 of the written value has no effect.
- R3: A pulse on `region_wr` clears the valid flag (bit 0 of `sw_rdata`) and leaves the pointer bits unchanged.
- R4: When `sw_wr` and `region_wr` are high in the same cycle, the software write wins, and the written value is read back.
- R5: An entry request made while the flag is clear gives `save_addr` equal to `region_base + region_size`, taken modulo 2^AW, with its two low bits forced to zero.
- R6: After such an entry, the register reads back that computed address with the valid flag set.
- R7: An entry request made while the flag is set gives the stored pointer (low two bits zero) as `save_addr`, whatever the region base and size are.
- R8: `save_valid` is high exactly in the cycle after each cycle in which `entry_req` is high. `save_addr` holds its value until the next entry.
- R9: An entry uses the register state from before its cycle. If `region_wr` or `sw_wr` is high in the same cycle, that update decides the register contents afterwards. An invalidation in that cycle leaves the flag clear and the pointer bits as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| region_base | input | AW | Base address of the managed memory region |
| region_size | input | AW | Size of the managed memory region in bytes |
| region_wr | input | 1 | Strobe: the region descriptor was written |
| entry_req | input | 1 | Mode-entry request, one cycle per entry |
| sw_wr | input | 1 | Software write strobe for the register |
| sw_wdata | input | AW | Software write value: pointer in AW-1..2, valid flag in bit 0 |
| sw_rdata | output | AW | Register read value: pointer, reserved zero, valid flag |
| save_valid | output | 1 | Ready pulse: `save_addr` is valid for this entry |
| save_addr | output | AW | Dword-aligned header address to use for the save |

## Verification
The bench builds the block with the default AW of 32. At this width the addition of base and size can carry out of the top bit, so the wraparound case of R5 is reachable with ordinary addresses. The full 30-bit pointer field is exercised by patterns that set and clear bits in both halves of the word. Unaligned base and size sums are used to show that the low two bits are dropped. Same-cycle collisions of entry, invalidation and software write are driven directly to pin down the priorities.

// File: rtl/smm_hdr_ptr.sv
module smm_hdr_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] region_base,
  input  logic [AW-1:0] region_size,
  input  logic          region_wr,
  input  logic          entry_req,
  input  logic          sw_wr,
  input  logic [AW-1:0] sw_wdata,
  output logic [AW-1:0] sw_rdata,
  output logic          save_valid,
  output logic [AW-1:0] save_addr
);
  localparam int PW = AW - 2;

  logic [PW-1:0] ptr_q;
  logic          vld_q;
  logic [PW-1:0] save_q;
  logic          save_v_q;

  wire [AW-1:0] top_w     = region_base + region_size;
  wire [PW-1:0] entry_ptr = vld_q ? ptr_q : top_w[AW-1:2];
  wire          unused_bits = &{1'b0, sw_wdata[1], top_w[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      vld_q    <= 1'b0;
      save_q   <= '0;
      save_v_q <= 1'b0;
    end else begin
      save_v_q <= entry_req;
      if (entry_req) save_q <= entry_ptr;
      if (sw_wr) begin
        ptr_q <= sw_wdata[AW-1:2];
        vld_q <= sw_wdata[0];
      end else if (region_wr) begin
        vld_q <= 1'b0;
      end else if (entry_req && !vld_q) begin
        ptr_q <= top_w[AW-1:2];
        vld_q <= 1'b1;
      end
    end
  end

  assign sw_rdata   = {ptr_q, 1'b0, vld_q};
  assign save_addr  = {save_q, 2'b00};
  assign save_valid = save_v_q;

  assert_entry_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    entry_req |=> save_valid);
  assert_no_spurious_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !entry_req |=> !save_valid);
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !entry_req |=> $stable(save_addr));
  assert_invalidate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (region_wr && !sw_wr) |=> (sw_rdata[0] == 1'b0) && (sw_rdata[AW-1:2] == $past(sw_rdata[AW-1:2])));
  assert_sw_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> (sw_rdata[AW-1:2] == $past(sw_wdata[AW-1:2])) && (sw_rdata[0] == $past(sw_wdata[0])));
  assert_lazy_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_req && !sw_rdata[0]) |=> save_addr[AW-1:2] == $past(top_w[AW-1:2]));
  assert_lazy_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_req && !sw_rdata[0] && !sw_wr && !region_wr) |=>
      sw_rdata[0] && (sw_rdata[AW-1:2] == save_addr[AW-1:2]));
  assert_valid_reuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_req && sw_rdata[0]) |=> save_addr == {$past(sw_rdata[AW-1:2]), 2'b00});
endmodule

// File: tb/smm_hdr_ptr_tb.sv
module smm_hdr_ptr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] region_base = '0;
  logic [31:0] region_size = '0;
  logic        region_wr = 1'b0;
  logic        entry_req = 1'b0;
  logic        sw_wr = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;
  logic        save_valid;
  logic [31:0] save_addr;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  smm_hdr_ptr #(.AW(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .region_base(region_base), .region_size(region_size),
    .region_wr(region_wr), .entry_req(entry_req), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .save_valid(save_valid), .save_addr(save_addr));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic cyc(input logic ent, input logic rw, input logic sw, input logic [31:0] wd);
    entry_req = ent; region_wr = rw; sw_wr = sw; sw_wdata = wd;
    @(negedge clk);
    entry_req = 1'b0; region_wr = 1'b0; sw_wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rdata", sw_rdata, 32'h0);
    check("R1 save_valid", {31'b0, save_valid}, 32'h0);
  endtask

  task automatic t_sw_write();
    cyc(0, 0, 1, 32'h1234_5677);
    check("R2 bit1 ignored", sw_rdata, 32'h1234_5675);
    cyc(0, 0, 1, 32'hABCD_0002);
    check("R2 flag clear", sw_rdata, 32'hABCD_0000);
  endtask

  task automatic t_invalidate();
    cyc(0, 0, 1, 32'h4000_0001);
    cyc(0, 1, 0, 32'h0);
    check("R3 invalidate", sw_rdata, 32'h4000_0000);
  endtask

  task automatic t_priority();
    cyc(0, 1, 1, 32'h5000_0001);
    check("R4 sw wins", sw_rdata, 32'h5000_0001);
  endtask

  task automatic t_lazy();
    cyc(0, 1, 0, 32'h0);
    region_base = 32'h0008_0000; region_size = 32'h0001_0000;
    cyc(1, 0, 0, 32'h0);
    check("R8 ready", {31'b0, save_valid}, 32'h1);
    check("R5 computed", save_addr, 32'h0009_0000);
    check("R6 loaded", sw_rdata, 32'h0009_0001);
    @(negedge clk);
    check("R8 pulse ends", {31'b0, save_valid}, 32'h0);
    check("R8 addr held", save_addr, 32'h0009_0000);
  endtask

  task automatic t_valid_used();
    region_base = 32'h2000_0000; region_size = 32'h0000_4000;
    cyc(1, 0, 0, 32'h0);
    check("R7 stored used", save_addr, 32'h0009_0000);
    cyc(0, 0, 1, 32'h7000_0001);
    cyc(1, 0, 0, 32'h0);
    check("R7 sw pointer used", save_addr, 32'h7000_0000);
    check("R7 register kept", sw_rdata, 32'h7000_0001);
  endtask

  task automatic t_wrap_align();
    cyc(0, 1, 0, 32'h0);
    region_base = 32'hFFFF_F000; region_size = 32'h0000_2000;
    cyc(1, 0, 0, 32'h0);
    check("R5 wrap", save_addr, 32'h0000_1000);
    cyc(0, 1, 0, 32'h0);
    region_base = 32'h0000_0100; region_size = 32'h0000_0007;
    cyc(1, 0, 0, 32'h0);
    check("R5 align", save_addr, 32'h0000_0104);
    check("R6 align", sw_rdata, 32'h0000_0105);
  endtask

  task automatic t_same_cycle();
    cyc(0, 0, 1, 32'h7000_0001);
    cyc(1, 1, 0, 32'h0);
    check("R9 entry+inval addr", save_addr, 32'h7000_0000);
    check("R9 entry+inval reg", sw_rdata, 32'h7000_0000);
    region_base = 32'h0008_0000; region_size = 32'h0001_0000;
    cyc(1, 0, 1, 32'h6000_0001);
    check("R9 entry+sw addr", save_addr, 32'h0009_0000);
    check("R9 entry+sw reg", sw_rdata, 32'h6000_0001);
  endtask

  task automatic t_back_to_back();
    entry_req = 1'b1;
    @(negedge clk);
    check("R8 first", {31'b0, save_valid}, 32'h1);
    @(negedge clk);
    entry_req = 1'b0;
    check("R8 second", {31'b0, save_valid}, 32'h1);
    @(negedge clk);
    check("R8 after", {31'b0, save_valid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sw_write();
    t_invalidate();
    t_priority();
    t_lazy();
    t_valid_used();
    t_wrap_align();
    t_same_cycle();
    t_back_to_back();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule